// File: doc/BRIEF.md
# Polled ADC Host Register Interface

This block lets a host processor run a 12-bit analog-to-digital converter through four byte-wide register offsets. The host picks one of eight single-ended channels and the simultaneous sample-and-hold mode by writing the channel offset. It starts a conversion by writing any value to the trigger offset. The block sends the converter a one-cycle start pulse and raises an end-of-conversion (EOC) flag, which stays high until the converter reports that it is done.

When the converter reports done, the block stores the 12-bit result in a holding register. The host reads the result left-justified across two byte offsets. The only way the host learns that a conversion has finished is by polling the EOC bit in the status byte. The status byte also shows the converter's unipolar/bipolar strap, two constant bits, the sample-and-hold setting and the current channel.

Top module: `adc_poll_ctrl`

## Requirements
- R1: After reset, the channel select is 0, sample-and-hold mode is 0, EOC is 0, the held result is 0 and `conv_start` is low. A status read then returns 0x20 with bit 6 set to `cfg_bipolar`.
- R2: A write to offset 2 loads data bits 2:0 into the channel select, which drives `mux_sel` and status bits 2:0. Data bits 7:4 of that write have no effect.
- R3: Data bit 3 of an offset-2 write sets the sample-and-hold mode, which drives `sh_mode` and status bit 4.
- R4: A write of any value to offset 0 while EOC is low is accepted. In the cycle after the write, `conv_start` is high for exactly one cycle and EOC reads 1.
- R5: A write to offset 0 while EOC is high is ignored. No start pulse is produced and EOC stays high.
- R6: When `conv_done` is high while EOC is high, EOC returns to 0 and `conv_result` is captured into the holding register at that clock edge.
- R7: A read of offset 1 returns held result bits 11:4. A read of offset 0 returns held result bits 3:0 in data bits 7:4, with bits 3:0 reading 0. `host_rdata` is 0 whenever `host_rd` is low.
- R8: A read of offset 3 returns the status byte: bit 7 is EOC, bit 6 is `cfg_bipolar`, bit 5 is 1, bit 4 is the sample-and-hold mode, bit 3 is 0, and bits 2:0 are the channel.
- R9: A `conv_done` pulse while EOC is low has no effect. The held result keeps its value until the next accepted completion.
- R10: Writes to offsets 1 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, combinational from the current state |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| mux_sel | output | 3 | Analog multiplexer channel select |
| sh_mode | output | 1 | Simultaneous sample-and-hold mode |
| cfg_bipolar | input | 1 | Converter input range strap (1 = bipolar) |

## Verification
The bench builds the block with its default parameters: a 12-bit result, a 3-bit channel and an 8-bit bus. With these values the split into a high byte and a high nibble can be observed exactly, and every status bit maps to a fixed position. The widths put all eight channel codes and the full result range within reach. The bench covers these cases:
- start commands arriving both while idle and while busy;
- completion pulses arriving both while idle and while busy;
- a change of the bipolar strap, which shows up in the status byte.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 2;
    localparam int RES_W  = 12;
    localparam int CH_W   = 3;

    // Status byte layout
    localparam int ST_EOC  = 7;
    localparam int ST_CFG  = 6;
    localparam int ST_ONE  = 5;
    localparam int ST_SH   = 4;
    localparam int ST_ZERO = 3;

    // Position of the sample-and-hold bit in a channel write
    localparam int SH_WBIT = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_RES_LO = 2'd0,
        OFS_RES_HI = 2'd1,
        OFS_CHAN   = 2'd2,
        OFS_STAT   = 2'd3
    } ofs_e;
endpackage

// File: rtl/adc_chan_reg.sv
module adc_chan_reg #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] sel_wdata,
    input  logic            sh_wdata,
    output logic [CH_W-1:0] sel_o,
    output logic            sh_o
);
    typedef struct packed {
        logic [CH_W-1:0] sel;
        logic            sh;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel = sel_wdata;
            st_d.sh  = sh_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.sel;
    assign sh_o  = st_q.sh;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             done,
    input  logic [RES_W-1:0] result_in,
    output logic             start_o,
    output logic             eoc_o,
    output logic [RES_W-1:0] result_o
);
    typedef struct packed {
        logic             eoc;
        logic             start;
        logic [RES_W-1:0] result;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (st_q.eoc) begin
            // busy: triggers are dropped, only completion matters
            if (done) begin
                st_d.eoc    = 1'b0;
                st_d.result = result_in;
            end
        end else if (trig) begin
            st_d.eoc   = 1'b1;
            st_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o  = st_q.start;
    assign eoc_o    = st_q.eoc;
    assign result_o = st_q.result;
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
    import adc_poll_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int CH_W  = 3
) (
    input  logic              rd,
    input  logic [OFS_W-1:0]  addr,
    input  logic              eoc,
    input  logic              cfg,
    input  logic              sh,
    input  logic [CH_W-1:0]   sel,
    input  logic [RES_W-1:0]  result,
    output logic [DATA_W-1:0] rdata
);
    localparam int LO_W  = RES_W - DATA_W;
    localparam int PAD_W = DATA_W - LO_W;

    logic [DATA_W-1:0] lo_byte, hi_byte, stat_byte;

    assign hi_byte = result[RES_W-1 -: DATA_W];

    generate
        if (PAD_W > 0) begin : g_pad
            assign lo_byte = {result[LO_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign lo_byte = result[LO_W-1 -: DATA_W];
        end
    endgenerate

    always_comb begin
        stat_byte          = '0;
        stat_byte[CH_W-1:0] = sel;
        stat_byte[ST_ZERO] = 1'b0;
        stat_byte[ST_SH]   = sh;
        stat_byte[ST_ONE]  = 1'b1;
        stat_byte[ST_CFG]  = cfg;
        stat_byte[ST_EOC]  = eoc;
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (ofs_e'(addr))
                OFS_RES_LO: rdata = lo_byte;
                OFS_RES_HI: rdata = hi_byte;
                OFS_CHAN:   rdata = '0;
                OFS_STAT:   rdata = stat_byte;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_poll_ctrl.sv
module adc_poll_ctrl
    import adc_poll_pkg::*;
#(
    parameter int RES_W_P = RES_W,
    parameter int CH_W_P  = CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OFS_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                host_wr,
    input  logic                host_rd,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                conv_start,
    input  logic                conv_done,
    input  logic [RES_W_P-1:0]  conv_result,
    output logic [CH_W_P-1:0]   mux_sel,
    output logic                sh_mode,
    input  logic                cfg_bipolar
);
    logic               trig_wr, chan_wr;
    logic               eoc_q;
    logic [RES_W_P-1:0] result_q;
    logic               unused_wbits;

    assign trig_wr = host_wr && (ofs_e'(host_addr) == OFS_RES_LO);
    assign chan_wr = host_wr && (ofs_e'(host_addr) == OFS_CHAN);
    assign unused_wbits = ^host_wdata[DATA_W-1:SH_WBIT+1];

    adc_chan_reg #(.CH_W(CH_W_P)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (chan_wr),
        .sel_wdata (host_wdata[CH_W_P-1:0]),
        .sh_wdata  (host_wdata[SH_WBIT]),
        .sel_o     (mux_sel),
        .sh_o      (sh_mode)
    );

    adc_conv_seq #(.RES_W(RES_W_P)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_wr),
        .done      (conv_done),
        .result_in (conv_result),
        .start_o   (conv_start),
        .eoc_o     (eoc_q),
        .result_o  (result_q)
    );

    adc_read_mux #(.RES_W(RES_W_P), .CH_W(CH_W_P)) u_rmux (
        .rd     (host_rd),
        .addr   (host_addr),
        .eoc    (eoc_q),
        .cfg    (cfg_bipolar),
        .sh     (sh_mode),
        .sel    (mux_sel),
        .result (result_q),
        .rdata  (host_rdata)
    );
endmodule

// File: rtl/adc_poll_ctrl_chk.sv
module adc_poll_ctrl_chk #(
    parameter int RES_W_P = 12,
    parameter int CH_W_P  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         host_addr,
    input logic [7:0]         host_wdata,
    input logic               host_wr,
    input logic               host_rd,
    input logic [7:0]         host_rdata,
    input logic               conv_start,
    input logic               conv_done,
    input logic [RES_W_P-1:0] conv_result,
    input logic [CH_W_P-1:0]  mux_sel,
    input logic               eoc_q,
    input logic [RES_W_P-1:0] result_q
);
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_eoc_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_q) |-> conv_start);

    assert_start_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd0 && eoc_q) |=> !conv_start);

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && eoc_q) |=> (!eoc_q && result_q == $past(conv_result)));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_done && eoc_q) |=> $stable(result_q));

    assert_chan_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2) |=> mux_sel == $past(host_wdata[CH_W_P-1:0]));

    assert_status_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd3) |-> (host_rdata[5] && !host_rdata[3]));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == 8'h00);
endmodule

bind adc_poll_ctrl adc_poll_ctrl_chk #(.RES_W_P(RES_W_P), .CH_W_P(CH_W_P)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .conv_start  (conv_start),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .mux_sel     (mux_sel),
    .eoc_q       (eoc_q),
    .result_q    (result_q)
);

// File: tb/adc_poll_ctrl_tb.sv
module adc_poll_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic [2:0]  mux_sel;
    logic        sh_mode;
    logic        cfg_bipolar = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    adc_poll_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
        .mux_sel(mux_sel), .sh_mode(sh_mode), .cfg_bipolar(cfg_bipolar)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read strobe against the scoreboard queue
    always @(negedge clk) begin
        #2;
        if (host_rd) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard-empty actual=%0h expected=none", host_rdata);
            end else begin
                check(tag_q.pop_front(), {24'd0, host_rdata}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic host_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic finish_conv(input logic [11:0] r);
        @(negedge clk);
        conv_result = r; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 conv_start", conv_start, 0);
        check("R1 mux_sel", mux_sel, 0);
        check("R1 sh_mode", sh_mode, 0);
        host_read(2'd3, 8'h20, "R1 status");
        host_read(2'd1, 8'h00, "R1 result hi");
        host_read(2'd0, 8'h00, "R1 result lo");

        // R2: channel 6, upper bits set but ignored
        host_write(2'd2, 8'hF6);
        check("R2 mux_sel", mux_sel, 6);
        check("R2 sh_mode stays", sh_mode, 0);
        host_read(2'd3, 8'h26, "R2 status chan");

        // R3: sample-and-hold bit plus channel 3
        host_write(2'd2, 8'h0B);
        check("R3 sh_mode", sh_mode, 1);
        check("R3 mux_sel", mux_sel, 3);
        host_read(2'd3, 8'h33, "R3 status sh");

        // R8: bipolar strap appears in bit 6
        cfg_bipolar = 1'b1;
        host_read(2'd3, 8'h73, "R8 status cfg");

        // R4: accepted trigger
        host_write(2'd0, 8'h5A);
        check("R4 start pulse", conv_start, 1);
        @(negedge clk);
        check("R4 start single", conv_start, 0);
        host_read(2'd3, 8'hF3, "R4 status eoc");

        // R5: trigger while busy ignored
        host_write(2'd0, 8'h00);
        check("R5 no start", conv_start, 0);
        @(negedge clk);
        check("R5 no start late", conv_start, 0);
        host_read(2'd3, 8'hF3, "R5 eoc held");

        // R6/R7: completion and result packing
        finish_conv(12'hABC);
        host_read(2'd3, 8'h73, "R6 eoc cleared");
        host_read(2'd1, 8'hAB, "R7 hi byte");
        host_read(2'd0, 8'hC0, "R7 lo nibble");
        @(negedge clk);
        check("R7 idle rdata", host_rdata, 0);

        // R9: completion while idle ignored
        finish_conv(12'h123);
        host_read(2'd1, 8'hAB, "R9 hi held");
        host_read(2'd0, 8'hC0, "R9 lo held");
        host_read(2'd3, 8'h73, "R9 eoc stays low");

        // R10: writes to offsets 1 and 3 change nothing
        host_write(2'd1, 8'hFF);
        host_write(2'd3, 8'hFF);
        check("R10 no start", conv_start, 0);
        host_read(2'd3, 8'h73, "R10 status same");
        host_read(2'd1, 8'hAB, "R10 hi same");
        host_read(2'd0, 8'hC0, "R10 lo same");

        // second conversion, channel changed while busy
        cfg_bipolar = 1'b0;
        host_write(2'd0, 8'h01);
        check("R4 second start", conv_start, 1);
        host_write(2'd2, 8'h07);
        host_read(2'd3, 8'hA7, "R2 chan while busy");
        finish_conv(12'h5A7);
        host_read(2'd1, 8'h5A, "R6 second hi");
        host_read(2'd0, 8'h70, "R6 second lo");
        host_read(2'd3, 8'h27, "R8 final status");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard-leftover actual=%0d expected=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule